// File: doc/BRIEF.md
# Host-to-PCI Address Window Translator

This block sits between a host memory bus and a PCI master cycle generator. It claims host accesses whose address lies in a fixed 1 GB window and turns each one into a single request for the PCI side. One control bit sets the kind of request. With the bit clear the block asks for a memory cycle, and a two-bit register field supplies the top of the 32-bit bus address. With the bit set the block asks for a configuration cycle. In that case it forwards a dword-aligned offset, in which a one-hot device select line sits at bit 13 plus the device number and the function number sits in bits 10:8. It refuses any offset of 1 MB or more without touching the bus.

The block handles one transaction at a time. It accepts a request with a valid/ready handshake and holds the PCI request until the cycle generator takes it. It then waits for the completion and returns a one-cycle response. A master abort reported by the PCI side sets a sticky status flag, which software clears by writing a one to it. An aborted access also forces its read data to all ones. Two software-visible registers sit behind a small write port and a registered read port: a control register and a status register.

Top module: `pci_window_xlate`

## Requirements
- R1: Only host addresses whose bits 31:30 equal 2'b10 (0x80000000 to 0xBFFFFFFF) are claimed: `host_ready` is high only for them while idle. Any other address is never acknowledged and produces no PCI request and no host response.
- R2: The control register is written with `csr_sel`=0. When its bit 1 is clear, a claimed access issues `pci_req_cfg`=0 with `pci_req_addr` = {control bits 3:2, host address bits 29:0}.
- R3: When control bit 1 is set, a claimed access issues `pci_req_cfg`=1 with `pci_req_addr` = host address bits 19:2 in place, and bits 31:20 and 1:0 zero. Control bits 3:2 are ignored in this mode.
- R4: In configuration mode, an access whose offset (host address bits 29:0) is 0x100000 or more issues no PCI request. It is answered with `host_rsp_err`=1, with read data 0xFFFFFFFF for a read and 0 for a write.
- R5: A completion with `pci_rsp_abort`=1 sets status bit 26 (register selected by `csr_sel`=1). The bit stays set until a status write has a one in bit 26. Writes with bit 26 at zero leave it set.
- R6: A completion without abort answers a read with `pci_rsp_rdata` and `host_rsp_err`=0. A completion with abort answers with `host_rsp_err`=1 and read data 0xFFFFFFFF. Write responses carry read data 0 unless they are aborted.
- R7: The PCI request carries the host byte enables, write flag and write data unchanged, and holds all fields stable until `pci_req_ready`.
- R8: Only one access is outstanding. `host_ready` stays low from acceptance until the response, the response comes at least one clock after acceptance, and `host_rsp_valid` is a single-cycle pulse.
- R9: After reset there is no PCI request and no host response, and both registers read back as zero. `csr_rdata` shows the register picked by `csr_sel` one clock later.
- R10: The cycle kind and the address are fixed when the access is accepted. A control register write during an outstanding access does not change that access's request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host request present |
| host_ready | output | 1 | Request accepted this cycle (window hit while idle) |
| host_addr | input | 32 | Host byte address |
| host_write | input | 1 | 1 = write, 0 = read |
| host_be | input | 4 | Host byte enables |
| host_wdata | input | 32 | Host write data |
| host_rsp_valid | output | 1 | One-cycle response strobe |
| host_rsp_rdata | output | 32 | Read data returned to the host |
| host_rsp_err | output | 1 | Access aborted or rejected |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 1 | 0 = control register, 1 = status register |
| csr_wdata | input | 32 | Register write data (status writes clear the bits set to one) |
| csr_rdata | output | 32 | Registered readback of the selected register |
| pci_req_valid | output | 1 | PCI cycle request present |
| pci_req_ready | input | 1 | Cycle generator takes the request |
| pci_req_cfg | output | 1 | 1 = configuration cycle, 0 = memory cycle |
| pci_req_write | output | 1 | Request is a write |
| pci_req_addr | output | 32 | PCI bus address |
| pci_req_be | output | 4 | Byte enables for the cycle |
| pci_req_wdata | output | 32 | Write data for the cycle |
| pci_rsp_valid | input | 1 | Completion of the issued cycle |
| pci_rsp_abort | input | 1 | Completion ended in master abort |
| pci_rsp_rdata | input | 32 | Read data of the completion |

## Verification
The assertions assume that the PCI side never reports a completion before it has taken the request. They also assume that the host keeps a request steady until it sees `host_ready`. The bench drives the completion only on the cycle after it has seen the request taken, and it holds a host request until acceptance or until it gives up on an unclaimed address. It keeps `pci_req_ready` high except in the one test that stalls it on purpose to change the mode while an access is pending.

// File: rtl/pwx_pkg.sv
package pwx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } pwx_state_t;

  localparam int PWX_MODE_BIT  = 1;
  localparam int PWX_HI_LSB    = 2;
  localparam int PWX_ABORT_BIT = 26;

endpackage

// File: rtl/pwx_decode.sv
module pwx_decode #(
  parameter int          ADDR_W     = 32,
  parameter int          CFG_SPAN_W = 20,
  parameter logic [1:0]  WIN_TAG    = 2'b10
) (
  input  logic [ADDR_W-1:0] haddr,
  input  logic              cfg_mode,
  input  logic [1:0]        hi_bits,
  output logic              hit,
  output logic              cfg_ok,
  output logic [ADDR_W-1:0] pci_addr
);
  localparam int OFF_W = ADDR_W - 2;

  logic [OFF_W-1:0]  offset;
  logic [ADDR_W-1:0] cfg_addr;
  logic [ADDR_W-1:0] mem_addr;

  assign offset = haddr[OFF_W-1:0];
  assign hit    = (haddr[ADDR_W-1:OFF_W] == WIN_TAG);
  assign cfg_ok = (offset[OFF_W-1:CFG_SPAN_W] == '0);

  always_comb begin
    cfg_addr = '0;
    cfg_addr[CFG_SPAN_W-1:2] = offset[CFG_SPAN_W-1:2];
  end

  assign mem_addr = {hi_bits, offset};
  assign pci_addr = cfg_mode ? cfg_addr : mem_addr;

endmodule

// File: rtl/pwx_csr.sv
module pwx_csr import pwx_pkg::*; #(
  parameter int DATA_W    = 32,
  parameter int ABORT_BIT = PWX_ABORT_BIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_we,
  input  logic              csr_sel,
  input  logic [DATA_W-1:0] csr_wdata,
  input  logic              abort_evt,
  output logic [DATA_W-1:0] csr_rdata,
  output logic              cfg_mode,
  output logic [1:0]        hi_bits
);
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] clr_vec;
  logic [DATA_W-1:0] set_vec;

  always_comb begin
    set_vec = '0;
    set_vec[ABORT_BIT] = abort_evt;
    clr_vec = (csr_we && csr_sel) ? csr_wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      stat_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (csr_we && !csr_sel) ctrl_q <= csr_wdata;
      stat_q  <= (stat_q & ~clr_vec) | set_vec;
      rdata_q <= csr_sel ? stat_q : ctrl_q;
    end
  end

  assign csr_rdata = rdata_q;
  assign cfg_mode  = ctrl_q[PWX_MODE_BIT];
  assign hi_bits   = ctrl_q[PWX_HI_LSB+1:PWX_HI_LSB];

  assert_abort_sets_R5: assert property (@(posedge clk) disable iff (rst)
    abort_evt |=> stat_q[ABORT_BIT]);

  assert_abort_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (stat_q[ABORT_BIT] && !(csr_we && csr_sel && csr_wdata[ABORT_BIT]))
      |=> stat_q[ABORT_BIT]);

endmodule

// File: rtl/pwx_seq.sv
module pwx_seq import pwx_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_write,
  input  logic [BE_W-1:0]   host_be,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              hit,
  input  logic              cfg_ok,
  input  logic              cfg_mode,
  input  logic [ADDR_W-1:0] xl_addr,
  output logic              host_rsp_valid,
  output logic [DATA_W-1:0] host_rsp_rdata,
  output logic              host_rsp_err,
  output logic              pci_req_valid,
  input  logic              pci_req_ready,
  output logic              pci_req_cfg,
  output logic              pci_req_write,
  output logic [ADDR_W-1:0] pci_req_addr,
  output logic [BE_W-1:0]   pci_req_be,
  output logic [DATA_W-1:0] pci_req_wdata,
  input  logic              pci_rsp_valid,
  input  logic              pci_rsp_abort,
  input  logic [DATA_W-1:0] pci_rsp_rdata,
  output logic              abort_evt
);
  pwx_state_t state;
  logic       wr_q;
  logic       accept;
  logic       done;

  assign host_ready = (state == ST_IDLE) && hit;
  assign accept     = host_valid && host_ready;
  assign done       = (state == ST_WAIT) && pci_rsp_valid;
  assign abort_evt  = done && pci_rsp_abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      wr_q           <= 1'b0;
      host_rsp_valid <= 1'b0;
      host_rsp_rdata <= '0;
      host_rsp_err   <= 1'b0;
      pci_req_valid  <= 1'b0;
      pci_req_cfg    <= 1'b0;
      pci_req_write  <= 1'b0;
      pci_req_addr   <= '0;
      pci_req_be     <= '0;
      pci_req_wdata  <= '0;
    end else begin
      host_rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            wr_q <= host_write;
            if (cfg_mode && !cfg_ok) begin
              host_rsp_valid <= 1'b1;
              host_rsp_err   <= 1'b1;
              host_rsp_rdata <= host_write ? '0 : '1;
              state          <= ST_RESP;
            end else begin
              pci_req_valid <= 1'b1;
              pci_req_cfg   <= cfg_mode;
              pci_req_write <= host_write;
              pci_req_addr  <= xl_addr;
              pci_req_be    <= host_be;
              pci_req_wdata <= host_wdata;
              state         <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (pci_req_ready) begin
            pci_req_valid <= 1'b0;
            state         <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (pci_rsp_valid) begin
            host_rsp_valid <= 1'b1;
            host_rsp_err   <= pci_rsp_abort;
            if (pci_rsp_abort)  host_rsp_rdata <= '1;
            else if (wr_q)      host_rsp_rdata <= '0;
            else                host_rsp_rdata <= pci_rsp_rdata;
            state <= ST_RESP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (pci_req_valid && !pci_req_ready) |=> (pci_req_valid && $stable(pci_req_addr)
      && $stable(pci_req_be) && $stable(pci_req_wdata) && $stable(pci_req_cfg)));

  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    host_rsp_valid |=> !host_rsp_valid);

  assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (pci_req_valid || host_rsp_valid) |-> !host_ready);

  assert_abort_ones_R6: assert property (@(posedge clk) disable iff (rst)
    (done && pci_rsp_abort && !wr_q) |=>
      (host_rsp_valid && host_rsp_err && host_rsp_rdata == '1));

endmodule

// File: rtl/pci_window_xlate.sv
module pci_window_xlate import pwx_pkg::*; #(
  parameter int         ADDR_W     = 32,
  parameter int         DATA_W     = 32,
  parameter int         BE_W       = DATA_W / 8,
  parameter int         CFG_SPAN_W = 20,
  parameter logic [1:0] WIN_TAG    = 2'b10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_write,
  input  logic [BE_W-1:0]   host_be,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_rsp_valid,
  output logic [DATA_W-1:0] host_rsp_rdata,
  output logic              host_rsp_err,
  input  logic              csr_we,
  input  logic              csr_sel,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  output logic              pci_req_valid,
  input  logic              pci_req_ready,
  output logic              pci_req_cfg,
  output logic              pci_req_write,
  output logic [ADDR_W-1:0] pci_req_addr,
  output logic [BE_W-1:0]   pci_req_be,
  output logic [DATA_W-1:0] pci_req_wdata,
  input  logic              pci_rsp_valid,
  input  logic              pci_rsp_abort,
  input  logic [DATA_W-1:0] pci_rsp_rdata
);
  logic              hit;
  logic              cfg_ok;
  logic              cfg_mode;
  logic [1:0]        hi_bits;
  logic [ADDR_W-1:0] xl_addr;
  logic              abort_evt;

  pwx_decode #(
    .ADDR_W(ADDR_W), .CFG_SPAN_W(CFG_SPAN_W), .WIN_TAG(WIN_TAG)
  ) u_decode (
    .haddr(host_addr), .cfg_mode(cfg_mode), .hi_bits(hi_bits),
    .hit(hit), .cfg_ok(cfg_ok), .pci_addr(xl_addr)
  );

  pwx_csr #(.DATA_W(DATA_W)) u_csr (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .abort_evt(abort_evt), .csr_rdata(csr_rdata),
    .cfg_mode(cfg_mode), .hi_bits(hi_bits)
  );

  pwx_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_seq (
    .clk(clk), .rst(rst),
    .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
    .host_be(host_be), .host_wdata(host_wdata),
    .hit(hit), .cfg_ok(cfg_ok), .cfg_mode(cfg_mode), .xl_addr(xl_addr),
    .host_rsp_valid(host_rsp_valid), .host_rsp_rdata(host_rsp_rdata),
    .host_rsp_err(host_rsp_err),
    .pci_req_valid(pci_req_valid), .pci_req_ready(pci_req_ready),
    .pci_req_cfg(pci_req_cfg), .pci_req_write(pci_req_write),
    .pci_req_addr(pci_req_addr), .pci_req_be(pci_req_be),
    .pci_req_wdata(pci_req_wdata),
    .pci_rsp_valid(pci_rsp_valid), .pci_rsp_abort(pci_rsp_abort),
    .pci_rsp_rdata(pci_rsp_rdata), .abort_evt(abort_evt)
  );

  assert_claim_window_R1: assert property (@(posedge clk) disable iff (rst)
    (host_valid && host_ready) |-> (host_addr[ADDR_W-1:ADDR_W-2] == WIN_TAG));

  assert_cfg_range_R4: assert property (@(posedge clk) disable iff (rst)
    (pci_req_valid && pci_req_cfg) |-> (pci_req_addr[ADDR_W-1:CFG_SPAN_W] == '0));

  assert_cfg_align_R3: assert property (@(posedge clk) disable iff (rst)
    (pci_req_valid && pci_req_cfg) |-> (pci_req_addr[1:0] == 2'b00));

endmodule

// File: tb/pci_window_xlate_test.sv
`timescale 1ns/1ps
module pci_window_xlate_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_valid = 1'b0;
  logic        host_ready;
  logic [31:0] host_addr = '0;
  logic        host_write = 1'b0;
  logic [3:0]  host_be = '0;
  logic [31:0] host_wdata = '0;
  logic        host_rsp_valid;
  logic [31:0] host_rsp_rdata;
  logic        host_rsp_err;
  logic        csr_we = 1'b0;
  logic        csr_sel = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        pci_req_valid;
  logic        pci_req_ready = 1'b1;
  logic        pci_req_cfg;
  logic        pci_req_write;
  logic [31:0] pci_req_addr;
  logic [3:0]  pci_req_be;
  logic [31:0] pci_req_wdata;
  logic        pci_rsp_valid = 1'b0;
  logic        pci_rsp_abort = 1'b0;
  logic [31:0] pci_rsp_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pci_window_xlate uut (.*);

  typedef struct packed {
    logic        cfg;
    logic [1:0]  hi;
    logic [31:0] addr;
    logic        wr;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic        abort;
    logic [31:0] prdata;
    logic        claim;
    logic        issue;
    logic [31:0] paddr;
    logic        err;
    logic [31:0] rdata;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd1, 32'h8123_4568, 1'b0, 4'hF, 32'h0,         1'b0, 32'hDEAD_BEEF, 1'b1, 1'b1, 32'h4123_4568, 1'b0, 32'hDEAD_BEEF},
    '{1'b0, 2'd3, 32'hBFFF_FFFC, 1'b1, 4'h3, 32'h1234_5678, 1'b0, 32'h0,         1'b1, 1'b1, 32'hFFFF_FFFC, 1'b0, 32'h0},
    '{1'b0, 2'd0, 32'h8000_0000, 1'b0, 4'hF, 32'h0,         1'b1, 32'h0BAD_0BAD, 1'b1, 1'b1, 32'h0000_0000, 1'b1, 32'hFFFF_FFFF},
    '{1'b1, 2'd0, 32'h8000_210C, 1'b0, 4'hF, 32'h0,         1'b0, 32'h0002_11AB, 1'b1, 1'b1, 32'h0000_210C, 1'b0, 32'h0002_11AB},
    '{1'b1, 2'd2, 32'h8001_0003, 1'b1, 4'h8, 32'hA5A5_0000, 1'b0, 32'h0,         1'b1, 1'b1, 32'h0001_0000, 1'b0, 32'h0},
    '{1'b1, 2'd0, 32'h8010_0000, 1'b0, 4'hF, 32'h0,         1'b0, 32'h0,         1'b1, 1'b0, 32'h0,         1'b1, 32'hFFFF_FFFF},
    '{1'b1, 2'd0, 32'h8004_0010, 1'b0, 4'hF, 32'h0,         1'b1, 32'h1234_0000, 1'b1, 1'b1, 32'h0004_0010, 1'b1, 32'hFFFF_FFFF},
    '{1'b0, 2'd0, 32'h7FFF_FFFC, 1'b0, 4'hF, 32'h0,         1'b0, 32'h0,         1'b0, 1'b0, 32'h0,         1'b0, 32'h0},
    '{1'b1, 2'd0, 32'hC000_0000, 1'b0, 4'hF, 32'h0,         1'b0, 32'h0,         1'b0, 1'b0, 32'h0,         1'b0, 32'h0},
    '{1'b1, 2'd0, 32'h800F_FFFC, 1'b0, 4'hF, 32'h0,         1'b0, 32'h55AA_0F0F, 1'b1, 1'b1, 32'h000F_FFFC, 1'b0, 32'h55AA_0F0F},
    '{1'b1, 2'd0, 32'hBFF0_0000, 1'b1, 4'hF, 32'h0,         1'b0, 32'h0,         1'b1, 1'b0, 32'h0,         1'b1, 32'h0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic csr_write(input logic sel, input logic [31:0] val);
    csr_we = 1'b1; csr_sel = sel; csr_wdata = val;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_read(input logic sel, output logic [31:0] val);
    csr_sel = sel;
    @(negedge clk);
    @(negedge clk);
    val = csr_rdata;
  endtask

  task automatic run_vec(input vec_t v);
    bit got;
    bit issued;
    csr_write(1'b0, {28'h0, v.hi, v.cfg, 1'b0});
    host_addr = v.addr; host_write = v.wr; host_be = v.be; host_wdata = v.wdata;
    host_valid = 1'b1;
    #1;
    check("R1 claim", {31'h0, host_ready}, {31'h0, v.claim});
    if (!v.claim) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check("R1 no request", {30'h0, pci_req_valid, host_rsp_valid}, 32'h0);
      end
      host_valid = 1'b0;
      return;
    end
    @(negedge clk);
    host_valid = 1'b0;
    got = 1'b0; issued = 1'b0;
    for (int n = 0; n < 12 && !got; n++) begin
      if (host_rsp_valid) begin
        check("R6 err", {31'h0, host_rsp_err}, {31'h0, v.err});
        check("R6 rdata", host_rsp_rdata, v.rdata);
        got = 1'b1;
      end else if (pci_req_valid && !issued) begin
        issued = 1'b1;
        if (v.cfg) check("R3 cfg address", pci_req_addr, v.paddr);
        else       check("R2 mem address", pci_req_addr, v.paddr);
        check("R3 cycle kind", {31'h0, pci_req_cfg}, {31'h0, v.cfg});
        check("R7 byte enables", {28'h0, pci_req_be}, {28'h0, v.be});
        check("R7 write flag", {31'h0, pci_req_write}, {31'h0, v.wr});
        check("R7 write data", pci_req_wdata, v.wdata);
        @(negedge clk);
        pci_rsp_valid = 1'b1; pci_rsp_abort = v.abort; pci_rsp_rdata = v.prdata;
        @(negedge clk);
        pci_rsp_valid = 1'b0; pci_rsp_abort = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    check("R4 issue", {31'h0, issued}, {31'h0, v.issue});
    check("R8 response seen", {31'h0, got}, 32'h1);
    @(negedge clk);
    check("R8 pulse", {31'h0, host_rsp_valid}, 32'h0);
  endtask

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 reset req", {30'h0, pci_req_valid, host_rsp_valid}, 32'h0);
    csr_read(1'b0, rv); check("R9 reset ctrl", rv, 32'h0);
    csr_read(1'b1, rv); check("R9 reset status", rv, 32'h0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R5: aborts seen in the table leave the sticky bit set
    csr_read(1'b1, rv); check("R5 abort flag set", rv, 32'h0400_0000);
    csr_write(1'b1, 32'hFBFF_FFFF);
    csr_read(1'b1, rv); check("R5 zero write keeps flag", rv, 32'h0400_0000);
    csr_write(1'b1, 32'h0400_0000);
    csr_read(1'b1, rv); check("R5 one write clears", rv, 32'h0);

    // R10 / R8: mode change while an access is stalled
    csr_write(1'b0, 32'h0);
    pci_req_ready = 1'b0;
    host_addr = 32'h8000_0040; host_write = 1'b0; host_be = 4'hF; host_valid = 1'b1;
    @(negedge clk);
    check("R8 request out", {31'h0, pci_req_valid}, 32'h1);
    check("R8 busy not ready", {31'h0, host_ready}, 32'h0);
    csr_write(1'b0, 32'h0000_0002);
    check("R10 kind kept", {31'h0, pci_req_cfg}, 32'h0);
    check("R10 address kept", pci_req_addr, 32'h0000_0040);
    check("R8 still busy", {31'h0, host_ready}, 32'h0);
    host_valid = 1'b0;
    pci_req_ready = 1'b1;
    @(negedge clk);
    pci_rsp_valid = 1'b1; pci_rsp_rdata = 32'h0000_1357;
    @(negedge clk);
    pci_rsp_valid = 1'b0;
    check("R6 stalled read data", host_rsp_rdata, 32'h0000_1357);
    check("R6 stalled valid", {31'h0, host_rsp_valid}, 32'h1);
    @(negedge clk);
    csr_read(1'b0, rv); check("R3 mode bit readback", rv, 32'h0000_0002);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule